// File: doc/BRIEF.md
# Fractional Clock Synthesizer with Symmetric Bit-Clock Divider

The block produces a programmable master clock whose rate is a fraction of a source rate, MULT/DIV with MULT not above DIV. The fraction comes from an accumulator. Each source edge adds MULT to the accumulator. Whenever the sum reaches DIV, that edge is passed to the master output and DIV is subtracted. Because the passed edges are spaced unevenly, the master clock has no fixed duty cycle. A second stage divides a chosen edge stream by an even integer. This stage toggles its output at a fixed edge count, so the bit clock it produces has an exact 50% duty cycle.

Everything runs in the core clock domain. Each source clock arrives as a one-cycle edge strobe. The master clock leaves as a one-cycle pulse for each passed edge. A new ratio is loaded with an update strobe. A small state machine with two states, `ST_RUN` and `ST_PEND`, handles the update. An accepted update moves it from `ST_RUN` to `ST_PEND`. While it is in `ST_PEND`, the busy flag is set. The next passed edge is the accumulator boundary: the transition back to `ST_RUN` happens there, the new ratio is loaded and the accumulator is cleared. Software polls the busy flag until it clears.

Top module: `fracclk_synth`

## Requirements
- R1: After reset, `mclk_o`, `bclk_o` and `busy_o` are low, and the ratio is 1/1, so every selected source edge produces one `mclk_o` pulse one cycle later.
- R2: Start from a cleared accumulator at ratio MULT/DIV. Over N selected source edges, where N is a multiple of DIV, exactly N*MULT/DIV master pulses appear.
- R3: `mult_m1_i` and `div_m1_i` hold the value minus one. The 8-bit multiplier field therefore covers MULT from 1 to 256, and a code of 255/255 passes every edge.
- R4: `msrc_sel_i` = 0 selects `src0_tick_i` and 1 selects `src1_tick_i`. Edges on the source that is not selected produce no master pulses.
- R5: An accepted update raises `busy_o` in the cycle after the strobe. `busy_o` falls at the next passed edge, in the same cycle as that edge's master pulse. The new ratio then starts from a cleared accumulator.
- R6: An update whose MULT exceeds its DIV is rejected. `busy_o` stays low and the previous ratio stays in use.
- R7: With bit-divide field F, `bclk_o` stays high for F+1 edges and low for F+1 edges, so the division factor is (F+1)*2.
- R8: `bsrc_sel_i` = 0 clocks the bit stage on every core cycle (the bus clock). `bsrc_sel_i` = 1 clocks it on master pulses.
- R9: `bclk_o` is low, and its edge counter is cleared, unless both `tx_en_i` and `bclk_en_i` are high.
- R10: An update strobe that arrives while `busy_o` is high is ignored. The ratio that was already pending is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0_tick_i | input | 1 | Edge strobe of source clock 0 |
| src1_tick_i | input | 1 | Edge strobe of source clock 1 |
| msrc_sel_i | input | 1 | Master source select (0: source 0, 1: source 1) |
| upd_i | input | 1 | Ratio update strobe |
| mult_m1_i | input | 8 | Multiplier minus one |
| div_m1_i | input | 12 | Divider minus one |
| bsrc_sel_i | input | 1 | Bit-stage source (0: bus clock, 1: master pulses) |
| bdiv_i | input | 8 | Bit-clock divide field F, factor (F+1)*2 |
| tx_en_i | input | 1 | Transmit enable |
| bclk_en_i | input | 1 | Bit-clock enable |
| mclk_o | output | 1 | Master clock pulse, one per passed edge |
| bclk_o | output | 1 | Bit clock with 50% duty cycle |
| busy_o | output | 1 | Ratio update pending |

## Verification
The accumulator assertion assumes the multiplier never exceeds the divider. The rejection logic guarantees this, and the bench deliberately issues an update that breaks the rule to confirm it is refused. The bit-stage assertions assume the divide field stays constant while the stage runs. The bench therefore changes `bdiv_i` and `bsrc_sel_i` only while the enables are low. Source strobes are one core cycle wide and arrive at most once per cycle, which is the form the fractional stage expects.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } upd_state_t;
endpackage

// File: rtl/fracclk_accum.sv
module fracclk_accum
    import fracclk_pkg::*;
#(
    parameter int MW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          upd_i,
    input  logic [MW-1:0] mult_m1_i,
    input  logic [DW-1:0] div_m1_i,
    output logic          mclk_o,
    output logic          busy_o
);
    localparam int AW = DW + 1;

    upd_state_t    state_q, state_d;
    logic [MW-1:0] cur_m1_q, pend_m1_q;
    logic [DW-1:0] cur_d1_q, pend_d1_q;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] mult_val, div_val, sum;
    logic          wrap, accept, legal;

    assign mult_val = AW'(cur_m1_q) + AW'(1);
    assign div_val  = AW'(cur_d1_q) + AW'(1);
    assign sum      = acc_q + mult_val;
    assign wrap     = tick_i && (sum >= div_val);
    assign legal    = AW'(mult_m1_i) <= AW'(div_m1_i);
    assign accept   = upd_i && (state_q == ST_RUN) && legal;
    assign busy_o   = (state_q == ST_PEND);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (accept) state_d = ST_PEND;
            ST_PEND: if (wrap)   state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            mclk_o    <= 1'b0;
            cur_m1_q  <= '0;
            cur_d1_q  <= '0;
            pend_m1_q <= '0;
            pend_d1_q <= '0;
        end else begin
            mclk_o <= wrap;
            if (accept) begin
                pend_m1_q <= mult_m1_i;
                pend_d1_q <= div_m1_i;
            end
            if (wrap && state_q == ST_PEND) begin
                acc_q    <= '0;
                cur_m1_q <= pend_m1_q;
                cur_d1_q <= pend_d1_q;
            end else if (wrap) begin
                acc_q <= sum - div_val;
            end else if (tick_i) begin
                acc_q <= sum;
            end
        end
    end

    // R2: accumulator remainder always stays below the active divider
    a_r2_acc_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div_val);
    // R4: a master pulse is always preceded by a selected source edge
    a_r4_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_o |-> $past(tick_i));
    // R5: busy clears only together with a master pulse
    a_r5_busy_falls_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> mclk_o);
    // R6: an illegal ratio never starts an update
    a_r6_reject_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !busy_o && (AW'(mult_m1_i) > AW'(div_m1_i))) |=> !busy_o);
    // R10: a pending ratio is not overwritten by a later strobe
    a_r10_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pend_m1_q) && $stable(pend_d1_q));
endmodule

// File: rtl/fracclk_bitdiv.sv
module fracclk_bitdiv #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    input  logic          run_i,
    input  logic [BW-1:0] div_m1_i,
    output logic          bclk_o
);
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            bclk_o <= 1'b0;
        end else if (edge_i) begin
            if (cnt_q >= div_m1_i) begin
                cnt_q  <= '0;
                bclk_o <= ~bclk_o;
            end else begin
                cnt_q <= cnt_q + BW'(1);
            end
        end
    end

    // R9: stopped stage holds the bit clock low
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !bclk_o);
    // R8: bit clock moves only on a selected edge or when stopping
    a_r8_toggle_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bclk_o) |-> ($past(edge_i) || !$past(run_i)));
    // R7: counter never passes the divide field while running with a fixed field
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $stable(div_m1_i)) |-> cnt_q <= div_m1_i);
endmodule

// File: rtl/fracclk_synth.sv
module fracclk_synth #(
    parameter int MW = 8,
    parameter int DW = 12,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src0_tick_i,
    input  logic          src1_tick_i,
    input  logic          msrc_sel_i,
    input  logic          upd_i,
    input  logic [MW-1:0] mult_m1_i,
    input  logic [DW-1:0] div_m1_i,
    input  logic          bsrc_sel_i,
    input  logic [BW-1:0] bdiv_i,
    input  logic          tx_en_i,
    input  logic          bclk_en_i,
    output logic          mclk_o,
    output logic          bclk_o,
    output logic          busy_o
);
    logic sel_tick, bit_edge, bit_run;

    assign sel_tick = msrc_sel_i ? src1_tick_i : src0_tick_i;
    assign bit_edge = bsrc_sel_i ? mclk_o : 1'b1;
    assign bit_run  = tx_en_i && bclk_en_i;

    fracclk_accum #(.MW(MW), .DW(DW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (sel_tick),
        .upd_i     (upd_i),
        .mult_m1_i (mult_m1_i),
        .div_m1_i  (div_m1_i),
        .mclk_o    (mclk_o),
        .busy_o    (busy_o)
    );

    fracclk_bitdiv #(.BW(BW)) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (bit_edge),
        .run_i    (bit_run),
        .div_m1_i (bdiv_i),
        .bclk_o   (bclk_o)
    );

    // R1: outputs quiet in the first cycle after reset release
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy_o && !bclk_o));
endmodule

// File: tb/fracclk_synth_tb.sv
module fracclk_synth_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src0 = 0, src1 = 0, msel = 0, upd = 0, bsel = 0, txen = 0, bcen = 0;
    logic [7:0]  mm1 = 0;
    logic [11:0] dm1 = 0;
    logic [7:0]  bdiv = 0;
    logic mclk, bclk, busy;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fracclk_synth dut_i (
        .clk(clk), .rst_n(rst_n), .src0_tick_i(src0), .src1_tick_i(src1),
        .msrc_sel_i(msel), .upd_i(upd), .mult_m1_i(mm1), .div_m1_i(dm1),
        .bsrc_sel_i(bsel), .bdiv_i(bdiv), .tx_en_i(txen), .bclk_en_i(bcen),
        .mclk_o(mclk), .bclk_o(bclk), .busy_o(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic run_ticks(input int n, input bit on1, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            src0 = !on1;
            src1 = on1;
            step();
            if (mclk) cnt++;
        end
        src0 = 0;
        src1 = 0;
    endtask

    task automatic set_ratio(input logic [7:0] m, input logic [11:0] d);
        int n = 0;
        mm1 = m; dm1 = d; upd = 1;
        step();
        upd = 0;
        check("R5 busy after update", busy, 1);
        src0 = 1;
        while (busy && n < 5000) begin step(); n++; end
        check("R5 busy falls with pulse", mclk, 1);
        src0 = 0;
    endtask

    task automatic t_reset();
        int c;
        check("R1 mclk reset", mclk, 0);
        check("R1 bclk reset", bclk, 0);
        check("R1 busy reset", busy, 0);
        run_ticks(5, 0, c);
        check("R1 ratio 1/1", c, 5);
    endtask

    task automatic t_fraction();
        int c;
        set_ratio(8'd2, 12'd6);
        run_ticks(70, 0, c);
        check("R2 ratio 3/7", c, 30);
        set_ratio(8'd0, 12'd4);
        run_ticks(40, 0, c);
        check("R2 ratio 1/5", c, 8);
        set_ratio(8'd255, 12'd255);
        run_ticks(20, 0, c);
        check("R3 ratio 256/256", c, 20);
    endtask

    task automatic t_reject();
        int c;
        set_ratio(8'd0, 12'd1);
        mm1 = 9; dm1 = 4; upd = 1;
        step();
        upd = 0;
        check("R6 busy stays low", busy, 0);
        run_ticks(20, 0, c);
        check("R6 old ratio kept", c, 10);
    endtask

    task automatic t_upd_while_busy();
        int c;
        int n = 0;
        mm1 = 0; dm1 = 2; upd = 1;
        step();
        check("R10 first update busy", busy, 1);
        mm1 = 0; dm1 = 0;
        step();
        upd = 0;
        src0 = 1;
        while (busy && n < 100) begin step(); n++; end
        src0 = 0;
        check("R10 busy cleared", busy, 0);
        run_ticks(30, 0, c);
        check("R10 first ratio applied", c, 10);
    endtask

    task automatic t_srcsel();
        int c;
        msel = 1;
        run_ticks(20, 0, c);
        check("R4 unselected source ignored", c, 0);
        run_ticks(20, 1, c);
        check("R4 selected source counted", c, 6);
        msel = 0;
    endtask

    task automatic measure(input string req, input bit tick, input int exp);
        int n = 0;
        int hi = 0;
        int lo = 0;
        src0 = tick;
        while (bclk && n < 500) begin step(); n++; end
        while (!bclk && n < 1000) begin step(); n++; end
        while (bclk && hi < 500) begin step(); hi++; end
        while (!bclk && lo < 500) begin step(); lo++; end
        src0 = 0;
        check({req, " high run"}, hi, exp);
        check({req, " low run"}, lo, exp);
    endtask

    task automatic t_bitclk();
        set_ratio(8'd0, 12'd1);
        txen = 0; bcen = 0; step();
        bsel = 0; bdiv = 1; txen = 1; bcen = 1;
        measure("R7 R8 bus F=1", 0, 2);
        txen = 0; step();
        bdiv = 3; txen = 1;
        measure("R7 bus F=3", 0, 4);
        txen = 0; step();
        bsel = 1; bdiv = 1; txen = 1;
        measure("R8 master F=1 ratio 1/2", 1, 4);
        txen = 0; step();
        bsel = 0;
    endtask

    task automatic t_enable();
        int hits = 0;
        bdiv = 0;
        txen = 1; bcen = 0;
        for (int i = 0; i < 20; i++) begin step(); if (bclk) hits++; end
        txen = 0; bcen = 1;
        for (int i = 0; i < 20; i++) begin step(); if (bclk) hits++; end
        check("R9 bclk low without both enables", hits, 0);
        bcen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_fraction();
        t_reject();
        t_upd_while_busy();
        t_srcsel();
        t_bitclk();
        t_enable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule